// File: doc/BRIEF.md
# Oscillator Stabilization Delay Counter

This block is a free-running prescaler clocked on the falling edge of the oscillator clock. It holds the internal bus clock enable low until the oscillator has had time to settle. That happens after power-on reset and again after each exit from stop mode. The same chain also divides the oscillator clock down for a watchdog. It has twelve counting stages. A thirteenth stage catches the carry out of the twelfth, fires for one cycle as the watchdog tap, and returns the chain to zero.

A stop request from the running core clears the chain and freezes it, because the oscillator is treated as stopped. A wake event (interrupt, break or reset) restarts counting from zero. The wake edge also samples the short-recovery option, which selects a 32-cycle delay instead of the normal 4096-cycle delay. The external reset pin is accepted at the boundary and has no effect on the count or on any output.

Top module: `osc_settle_timer`

## Requirements
- R1: While `rst_n` is low, `bus_clk_en_o`, `rec_done_o` and `wdog_tap_o` are all 0.
- R2: After `rst_n` rises, `bus_clk_en_o` rises on the 4098th falling clock edge (two synchronizer edges plus 4096 counting edges), with no `rec_done_o` pulse.
- R3: `wdog_tap_o` is a one-cycle pulse each time the twelve-stage chain wraps from 4095 to 0, so it pulses once every 4096 counting edges.
- R4: A falling edge that samples `stop_req_i` high while `bus_clk_en_o` is 1 drops `bus_clk_en_o` at that edge and clears the chain to 0. No `wdog_tap_o` pulse occurs while stopped.
- R5: A falling edge that samples `wake_i` high while stopped with `short_rec_i` = 0 starts a full recovery. `bus_clk_en_o` rises and `rec_done_o` pulses on the 4096th falling edge after the wake edge.
- R6: The same wake with `short_rec_i` = 1 starts a short recovery ending on the 32nd falling edge after the wake edge. The next `wdog_tap_o` then comes 4096 edges after the wake edge.
- R7: `short_rec_i` is sampled only on the wake edge; its value before and after that edge has no effect.
- R8: `ext_rst_i` has no effect on the count or on any output.
- R9: When a stop request falls on the edge where the chain would wrap, the stop wins. No `wdog_tap_o` pulse is given, and the chain restarts from 0 on the next wake.
- R10: `wake_i` is ignored unless stopped, and `stop_req_i` is ignored unless `bus_clk_en_o` is 1.
- R11: `rec_done_o` lasts exactly one cycle and coincides with `bus_clk_en_o` being 1. `bus_clk_en_o` stays 1 until the next accepted stop request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock; all state advances on its falling edge |
| rst_n | input | 1 | Power-on reset, active low, asynchronous assert, synchronized release |
| stop_req_i | input | 1 | Stop-mode entry request from the core |
| wake_i | input | 1 | Wake event (interrupt, break or reset) |
| short_rec_i | input | 1 | 1 selects the 32-cycle recovery, 0 the 4096-cycle one |
| ext_rst_i | input | 1 | External reset pin, ignored by this block |
| bus_clk_en_o | output | 1 | Internal bus clock enable |
| rec_done_o | output | 1 | One-cycle pulse when a stop recovery completes |
| wdog_tap_o | output | 1 | Watchdog clock tap from the thirteenth stage |

## Verification
Two functions can land on the same edge: the carry into the thirteenth stage, which would give a watchdog tap, and acceptance of a stop request, which clears the chain. The bench times a stop request so that it is sampled on exactly the edge where the chain is at 4095. It then expects only the bus-enable fall at that edge, no tap during the stop, and a fresh 4096-edge spacing from the next wake. A second overlap comes at the end of a full recovery, where the bus-enable rise, the done pulse and the tap share one edge. The scoreboard requires all three at that edge, in a fixed order.

// File: rtl/osc_settle_pkg.sv
package osc_settle_pkg;
  typedef enum logic [1:0] {
    MODE_POR   = 2'd0,
    MODE_RUN   = 2'd1,
    MODE_STOP  = 2'd2,
    MODE_RECOV = 2'd3
  } osc_mode_e;
endpackage

// File: rtl/osc_rst_sync.sv
module osc_rst_sync #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk_i,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [DEPTH-1:0] sync_q;
  logic [DEPTH-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[DEPTH-2:0], 1'b1};
  end

  always_ff @(negedge clk_i or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[DEPTH-1];
endmodule

// File: rtl/osc_stage_chain.sv
module osc_stage_chain #(
  parameter int unsigned STAGES = 12
) (
  input  logic              clk_i,
  input  logic              rst_n,
  input  logic              cnt_en_i,
  input  logic              clr_i,
  output logic [STAGES-1:0] cnt_o,
  output logic              tap_o
);
  logic [STAGES-1:0] cnt_q;
  logic [STAGES-1:0] cnt_d;
  logic [STAGES:0]   carry;
  logic              tap_q;
  logic              tap_d;

  assign carry[0] = cnt_en_i;

  // one toggle stage per bit; the carry out of the last feeds the tap stage
  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    assign carry[g+1] = carry[g] & cnt_q[g];
    always_comb begin
      cnt_d[g] = clr_i ? 1'b0 : (cnt_q[g] ^ carry[g]);
    end
  end

  always_comb begin
    tap_d = carry[STAGES] & ~clr_i;
  end

  always_ff @(negedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tap_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      tap_q <= tap_d;
    end
  end

  assign cnt_o = cnt_q;
  assign tap_o = tap_q;
endmodule

// File: rtl/osc_settle_ctrl.sv
module osc_settle_ctrl
  import osc_settle_pkg::*;
#(
  parameter int unsigned STAGES     = 12,
  parameter int unsigned SHORT_LOG2 = 5
) (
  input  logic              clk_i,
  input  logic              rst_n,
  input  logic              stop_req_i,
  input  logic              wake_i,
  input  logic              short_rec_i,
  input  logic [STAGES-1:0] cnt_i,
  output logic              cnt_en_o,
  output logic              cnt_clr_o,
  output logic              bus_en_o,
  output logic              done_o
);
  localparam int unsigned       SHORT_TC_INT = (1 << SHORT_LOG2) - 1;
  localparam logic [STAGES-1:0] SHORT_TC     = SHORT_TC_INT[STAGES-1:0];
  localparam logic [STAGES-1:0] FULL_TC      = {STAGES{1'b1}};

  osc_mode_e mode_q, mode_d;
  logic      short_q, short_d;
  logic      bus_en_q, bus_en_d;
  logic      done_q, done_d;
  logic      full_hit, short_hit, recov_hit;

  assign full_hit  = (cnt_i == FULL_TC);
  assign short_hit = (cnt_i == SHORT_TC);
  assign recov_hit = short_q ? short_hit : full_hit;

  always_comb begin
    mode_d    = mode_q;
    short_d   = short_q;
    bus_en_d  = bus_en_q;
    done_d    = 1'b0;
    cnt_en_o  = (mode_q != MODE_STOP);
    cnt_clr_o = 1'b0;
    unique case (mode_q)
      MODE_POR: begin
        if (full_hit) begin
          mode_d   = MODE_RUN;
          bus_en_d = 1'b1;
        end
      end
      MODE_RUN: begin
        if (stop_req_i) begin
          mode_d    = MODE_STOP;
          bus_en_d  = 1'b0;
          cnt_clr_o = 1'b1;
        end
      end
      MODE_STOP: begin
        if (wake_i) begin
          mode_d  = MODE_RECOV;
          short_d = short_rec_i;
        end
      end
      MODE_RECOV: begin
        if (recov_hit) begin
          mode_d   = MODE_RUN;
          bus_en_d = 1'b1;
          done_d   = 1'b1;
        end
      end
      default: mode_d = MODE_POR;
    endcase
  end

  always_ff @(negedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= MODE_POR;
      short_q  <= 1'b0;
      bus_en_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      mode_q   <= mode_d;
      short_q  <= short_d;
      bus_en_q <= bus_en_d;
      done_q   <= done_d;
    end
  end

  assign bus_en_o = bus_en_q;
  assign done_o   = done_q;
endmodule

// File: rtl/osc_settle_timer.sv
module osc_settle_timer #(
  parameter int unsigned STAGES     = 12,
  parameter int unsigned SHORT_LOG2 = 5,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic clk_i,
  input  logic rst_n,
  input  logic stop_req_i,
  input  logic wake_i,
  input  logic short_rec_i,
  input  logic ext_rst_i,
  output logic bus_clk_en_o,
  output logic rec_done_o,
  output logic wdog_tap_o
);
  logic              rst_sync_n;
  logic [STAGES-1:0] cnt;
  logic              cnt_en;
  logic              cnt_clr;
  logic              ext_rst_unused;

  // the pin is accepted but deliberately drives nothing
  assign ext_rst_unused = ext_rst_i;

  osc_rst_sync #(.DEPTH(SYNC_DEPTH)) u_rst_sync (
    .clk_i      (clk_i),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  osc_stage_chain #(.STAGES(STAGES)) u_chain (
    .clk_i    (clk_i),
    .rst_n    (rst_sync_n),
    .cnt_en_i (cnt_en),
    .clr_i    (cnt_clr),
    .cnt_o    (cnt),
    .tap_o    (wdog_tap_o)
  );

  osc_settle_ctrl #(.STAGES(STAGES), .SHORT_LOG2(SHORT_LOG2)) u_ctrl (
    .clk_i       (clk_i),
    .rst_n       (rst_sync_n),
    .stop_req_i  (stop_req_i),
    .wake_i      (wake_i),
    .short_rec_i (short_rec_i),
    .cnt_i       (cnt),
    .cnt_en_o    (cnt_en),
    .cnt_clr_o   (cnt_clr),
    .bus_en_o    (bus_clk_en_o),
    .done_o      (rec_done_o)
  );
endmodule

// File: rtl/osc_settle_checker.sv
module osc_settle_checker (
  input logic clk_i,
  input logic rst_n,
  input logic stop_req_i,
  input logic wake_i,
  input logic bus_clk_en_o,
  input logic rec_done_o,
  input logic wdog_tap_o
);
  // R1: outputs quiet while power-on reset is held
  always @(negedge clk_i) begin
    if (!rst_n) begin
      a_r1_quiet_in_reset: assert (!bus_clk_en_o && !rec_done_o && !wdog_tap_o)
        else $error("R1 output active during reset");
    end
  end

  a_r11_done_single: assert property (@(negedge clk_i) disable iff (!rst_n)
    rec_done_o |=> !rec_done_o);

  a_r11_done_with_bus: assert property (@(negedge clk_i) disable iff (!rst_n)
    rec_done_o |-> bus_clk_en_o);

  a_r11_bus_holds: assert property (@(negedge clk_i) disable iff (!rst_n)
    (bus_clk_en_o && !stop_req_i) |=> bus_clk_en_o);

  a_r3_tap_single: assert property (@(negedge clk_i) disable iff (!rst_n)
    wdog_tap_o |=> !wdog_tap_o);

  a_r4_stop_drops_bus: assert property (@(negedge clk_i) disable iff (!rst_n)
    (bus_clk_en_o && stop_req_i) |=> !bus_clk_en_o);

  a_r9_stop_beats_tap: assert property (@(negedge clk_i) disable iff (!rst_n)
    (bus_clk_en_o && stop_req_i) |=> !wdog_tap_o);

  a_r10_wake_ignored_running: assert property (@(negedge clk_i) disable iff (!rst_n)
    (bus_clk_en_o && wake_i && !stop_req_i) |=> !rec_done_o);
endmodule

bind osc_settle_timer osc_settle_checker u_chk (
  .clk_i        (clk_i),
  .rst_n        (rst_n),
  .stop_req_i   (stop_req_i),
  .wake_i       (wake_i),
  .bus_clk_en_o (bus_clk_en_o),
  .rec_done_o   (rec_done_o),
  .wdog_tap_o   (wdog_tap_o)
);

// File: tb/test_osc_settle_timer.sv
module test_osc_settle_timer;
  localparam int K_RISE = 0;
  localparam int K_FALL = 1;
  localparam int K_DONE = 2;
  localparam int K_TAP  = 3;

  typedef struct {
    int    kind;
    int    edge_no;
    string req;
  } ev_t;

  logic clk;
  logic rst_n;
  logic stop_req, wake, short_rec, ext_rst;
  logic bus_en, done, tap;

  int   ncount;
  int   n_chk;
  int   n_bad;
  bit   finished;
  logic prev_bus;
  ev_t  exp_q[$];

  osc_settle_timer i_osc_settle_timer (
    .clk_i        (clk),
    .rst_n        (rst_n),
    .stop_req_i   (stop_req),
    .wake_i       (wake),
    .short_rec_i  (short_rec),
    .ext_rst_i    (ext_rst),
    .bus_clk_en_o (bus_en),
    .rec_done_o   (done),
    .wdog_tap_o   (tap)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  initial ncount = 0;
  always @(negedge clk) ncount <= ncount + 1;

  function automatic string kname(int k);
    case (k)
      K_RISE:  return "bus_rise";
      K_FALL:  return "bus_fall";
      K_DONE:  return "done";
      default: return "tap";
    endcase
  endfunction

  task automatic push_ev(int kind, int e, string req);
    ev_t it;
    it.kind = kind;
    it.edge_no = e;
    it.req = req;
    exp_q.push_back(it);
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wait_edge(int e);
    while (ncount < e) step(1);
  endtask

  task automatic observe(int kind);
    ev_t it;
    n_chk++;
    if (exp_q.size() == 0) begin
      n_bad++;
      $display("FAIL unexpected: actual %s at edge %0d, expected no event", kname(kind), ncount);
    end else begin
      it = exp_q.pop_front();
      if (it.kind != kind || it.edge_no != ncount) begin
        n_bad++;
        $display("FAIL %s: actual %s at edge %0d, expected %s at edge %0d",
                 it.req, kname(kind), ncount, kname(it.kind), it.edge_no);
      end
    end
  endtask

  // monitor: outputs settle after the falling edge, sampled on the rising edge
  always @(posedge clk) begin
    if (rst_n && !finished) begin
      if (bus_en && !prev_bus) observe(K_RISE);
      if (!bus_en && prev_bus) observe(K_FALL);
      if (done) observe(K_DONE);
      if (tap)  observe(K_TAP);
    end
    prev_bus <= bus_en;
  end

  task automatic check_quiet(string req);
    n_chk++;
    if (bus_en !== 1'b0 || done !== 1'b0 || tap !== 1'b0) begin
      n_bad++;
      $display("FAIL %s: actual bus=%b done=%b tap=%b, expected 0 0 0", req, bus_en, done, tap);
    end
  endtask

  initial begin
    finished = 1'b0;
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_bad++;
      $display("FAIL watchdog: actual run still active, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int r0, s, e, t;
    n_chk = 0; n_bad = 0; prev_bus = 1'b0;
    rst_n = 1'b0; stop_req = 1'b0; wake = 1'b0; short_rec = 1'b0; ext_rst = 1'b0;
    step(3);
    check_quiet("R1");
    stop_req = 1'b1; wake = 1'b1; short_rec = 1'b1;
    step(2);
    check_quiet("R1");
    stop_req = 1'b0; wake = 1'b0; short_rec = 1'b0;
    step(1);
    check_quiet("R1");

    // R2: power-on delay, R3: tap at wrap
    rst_n = 1'b1;
    r0 = ncount;
    push_ev(K_RISE, r0 + 4098, "R2");
    push_ev(K_TAP,  r0 + 4098, "R3");
    step(1000);
    // R8: external reset pulse while counting must not move any event
    ext_rst = 1'b1; step(40); ext_rst = 1'b0;
    wait_edge(r0 + 4098 + 5);
    push_ev(K_TAP, r0 + 4098 + 4096, "R3");
    // R10: wake while running is ignored; R8 again while running
    wake = 1'b1; step(2); wake = 1'b0;
    ext_rst = 1'b1; step(3); ext_rst = 1'b0;
    wait_edge(r0 + 4098 + 4096 + 20);

    // R4: stop entry, then R5/R7: full recovery with the option bit dropping at wake
    short_rec = 1'b1;
    stop_req = 1'b1;
    s = ncount + 1;
    push_ev(K_FALL, s, "R4");
    step(1);
    stop_req = 1'b0;
    step(200);
    short_rec = 1'b0;
    wake = 1'b1;
    e = ncount + 1;
    push_ev(K_RISE, e + 4096, "R5");
    push_ev(K_DONE, e + 4096, "R5");
    push_ev(K_TAP,  e + 4096, "R5");
    step(1);
    wake = 1'b0;
    short_rec = 1'b1;  // R7: late change is ignored
    wait_edge(e + 4096 + 10);

    // R6/R7: short recovery
    short_rec = 1'b0;
    stop_req = 1'b1;
    s = ncount + 1;
    push_ev(K_FALL, s, "R4");
    step(1);
    stop_req = 1'b0;
    step(20);
    short_rec = 1'b1;
    wake = 1'b1;
    e = ncount + 1;
    push_ev(K_RISE, e + 32, "R6");
    push_ev(K_DONE, e + 32, "R6");
    step(1);
    wake = 1'b0;
    short_rec = 1'b0;  // R7
    step(4);
    // R10: stop request during recovery is ignored
    stop_req = 1'b1; step(1); stop_req = 1'b0;
    // R9: stop sampled on the wrap edge suppresses the tap
    t = e + 4096;
    wait_edge(t - 1);
    stop_req = 1'b1;
    push_ev(K_FALL, t, "R9");
    step(1);
    stop_req = 1'b0;
    step(300);
    short_rec = 1'b1;
    wake = 1'b1;
    e = ncount + 1;
    push_ev(K_RISE, e + 32,   "R9");
    push_ev(K_DONE, e + 32,   "R9");
    push_ev(K_TAP,  e + 4096, "R9");
    step(1);
    wake = 1'b0;
    wait_edge(e + 4096 + 10);

    n_chk++;
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R3: actual %0d events missing, expected 0", exp_q.size());
    end
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule